// File: doc/BRIEF.md
# Multiplexed Address/Data External Memory Bridge

This block sits between a CPU-side data-space request port and an external byte-wide static RAM. On the memory side the low address byte and the data byte share one set of pins. The high address byte has its own pins. An address-latch pulse and active-low read and write strobes complete the bus. An external latch, clocked by the falling edge of the latch pulse, holds the low address while the shared pins carry data.

An enable input switches the external bus on. While it is on, the bridge owns both pin groups and ignores the general-purpose output and direction values for them. While it is off, those values pass straight to the pins and every address goes to internal RAM. With the bus on, an address up to and including the internal boundary also goes to internal RAM and completes in one cycle. An address above the boundary runs four phases: address, latch, strobe and done. The CPU holds its request until ready goes high.

Top module: `xmem_bridge`

## Requirements
- R1: After reset, and while no external access is in progress, the latch output is low and both strobes are high.
- R2: With the bus on, a request to an address not above BOUNDARY raises ready in the same cycle and drives the internal read or write output. Read data comes from the internal RAM input. No external strobe is asserted.
- R3: With the bus off, every address, including those above BOUNDARY, goes to internal RAM. The shared and high pins then show the general-purpose output and direction inputs unchanged.
- R4: An external access first holds the latch output high for one cycle, with the low address byte driven on the shared pins (all enables 1) and the high byte on the high pins. In the next cycle the latch output is low and the shared pins still hold the low address. The latch output stays low for the whole strobe phase.
- R5: An external write holds the write strobe low for STROBE_CYCLES cycles, with the write data driven on all shared pins. The data lands at the full 16-bit address in the external memory.
- R6: An external read holds the read strobe low for STROBE_CYCLES cycles, with every shared-pin output enable at 0. The shared-pin input is captured at the last strobe cycle and returned on the read data output with ready.
- R7: During an external access ready stays low. It goes high in the done phase, exactly 3+STROBE_CYCLES cycles after the cycle in which the request was first seen.
- R8: The read and write strobes are never low together, and no shared-pin enable is 1 while the read strobe is low.
- R9: The address equal to BOUNDARY is internal. BOUNDARY+1 is external.
- R10: With the bus on and no access running, the shared-pin enables are all 0 and the high-pin enables are all 1, whatever the direction inputs say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_en_i | input | 1 | External bus enable |
| req_rd_i | input | 1 | CPU read request |
| req_wr_i | input | 1 | CPU write request |
| req_addr_i | input | 16 | CPU byte address |
| req_wdata_i | input | 8 | CPU write data |
| req_rdata_o | output | 8 | CPU read data, valid with ready |
| req_ready_o | output | 1 | Access complete |
| int_rd_o | output | 1 | Internal RAM read |
| int_wr_o | output | 1 | Internal RAM write |
| int_rdata_i | input | 8 | Internal RAM read data |
| gp_ad_out_i | input | 8 | General-purpose output value, shared pins |
| gp_ad_dir_i | input | 8 | General-purpose direction, shared pins (1 = drive) |
| gp_ah_out_i | input | 8 | General-purpose output value, high pins |
| gp_ah_dir_i | input | 8 | General-purpose direction, high pins |
| ad_o | output | 8 | Shared pin output value |
| ad_oe_o | output | 8 | Shared pin output enable per bit |
| ad_i | input | 8 | Shared pin input value |
| ah_o | output | 8 | High pin output value |
| ah_oe_o | output | 8 | High pin output enable per bit |
| ale_o | output | 1 | Address latch pulse |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
The bench runs accesses to addresses below BOUNDARY, at it, and just above it. This shows where the decode splits internal from external traffic. External writes and reads use addresses whose high and low bytes differ, such as 0x1234 and 0xFF01. Each read-back therefore checks that both halves of the address reach the memory through the latch. Bus-off accesses to an external-range address, and idle cycles with the bus on against arbitrary direction inputs, show the enable overriding the general-purpose pin settings. The phase-by-phase pin record of each external access tells a correct latch/strobe order apart from a shifted or overlapping one.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_LATCH = 3'd2,
    PH_STRB  = 3'd3,
    PH_DONE  = 3'd4
  } xmem_phase_e;
endpackage

// File: rtl/xmem_decode.sv
module xmem_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BOUNDARY = 16'h025F
) (
  input  logic              ext_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_ext_o
);
  localparam logic [ADDR_W-1:0] BOUND_C = ADDR_W'(BOUNDARY);

  // strictly above the boundary, and only while the bus is on
  assign is_ext_o = ext_en_i && (addr_i > BOUND_C);
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned STROBE_CYCLES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     start_wr_i,
  input  logic [ADDR_W-1:0]        start_addr_i,
  input  logic [DATA_W-1:0]        start_wdata_i,
  input  logic [DATA_W-1:0]        bus_in_i,
  output logic                     idle_o,
  output logic                     done_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     ale_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [DATA_W-1:0]        ad_out_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] ah_out_o
);
  localparam int unsigned HI_W  = ADDR_W - DATA_W;
  localparam int unsigned CNT_W = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYCLES - 1);

  xmem_phase_e      phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wr_q;
  logic              last_strb;

  assign last_strb = (phase_q == PH_STRB) && (cnt_q == CNT_LAST);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i) phase_d = PH_ADDR;
      PH_ADDR:  phase_d = PH_LATCH;
      PH_LATCH: phase_d = PH_STRB;
      PH_STRB:  if (last_strb) phase_d = PH_DONE;
      PH_DONE:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_IDLE && start_i) begin
        addr_q  <= start_addr_i;
        wdata_q <= start_wdata_i;
        wr_q    <= start_wr_i;
      end
      if (phase_q == PH_STRB && !last_strb) cnt_q <= cnt_q + 1'b1;
      else cnt_q <= '0;
      // sample the pins while the read strobe is still low
      if (last_strb && !wr_q) rdata_q <= bus_in_i;
    end
  end

  assign idle_o   = (phase_q == PH_IDLE);
  assign done_o   = (phase_q == PH_DONE);
  assign rdata_o  = rdata_q;
  assign ale_o    = (phase_q == PH_ADDR);
  assign rd_no    = !((phase_q == PH_STRB) && !wr_q);
  assign wr_no    = !((phase_q == PH_STRB) && wr_q);
  assign ah_out_o = addr_q[ADDR_W-1 -: HI_W];

  always_comb begin
    ad_out_o = '0;
    ad_oe_o  = 1'b0;
    unique case (phase_q)
      PH_ADDR, PH_LATCH: begin
        ad_out_o = addr_q[DATA_W-1:0];
        ad_oe_o  = 1'b1;
      end
      PH_STRB: if (wr_q) begin
        ad_out_o = wdata_q;
        ad_oe_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xmem_pad_mux.sv
module xmem_pad_mux #(
  parameter int unsigned W = 8
) (
  input  logic         own_i,
  input  logic [W-1:0] bus_out_i,
  input  logic [W-1:0] bus_oe_i,
  input  logic [W-1:0] gp_out_i,
  input  logic [W-1:0] gp_dir_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign pad_out_o[b] = own_i ? bus_out_i[b] : gp_out_i[b];
    assign pad_oe_o[b]  = own_i ? bus_oe_i[b]  : gp_dir_i[b];
  end
endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge
  import xmem_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned BOUNDARY      = 16'h025F,
  parameter int unsigned STROBE_CYCLES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ext_en_i,
  input  logic                     req_rd_i,
  input  logic                     req_wr_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic [DATA_W-1:0]        req_rdata_o,
  output logic                     req_ready_o,
  output logic                     int_rd_o,
  output logic                     int_wr_o,
  input  logic [DATA_W-1:0]        int_rdata_i,
  input  logic [DATA_W-1:0]        gp_ad_out_i,
  input  logic [DATA_W-1:0]        gp_ad_dir_i,
  input  logic [ADDR_W-DATA_W-1:0] gp_ah_out_i,
  input  logic [ADDR_W-DATA_W-1:0] gp_ah_dir_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic [DATA_W-1:0]        ad_oe_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [ADDR_W-DATA_W-1:0] ah_o,
  output logic [ADDR_W-DATA_W-1:0] ah_oe_o,
  output logic                     ale_o,
  output logic                     rd_no,
  output logic                     wr_no
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic              is_ext, any_req, start;
  logic              seq_idle, seq_done, bus_oe;
  logic [DATA_W-1:0] seq_rdata, bus_ad;
  logic [HI_W-1:0]   bus_ah;

  assign any_req = req_rd_i || req_wr_i;

  xmem_decode #(.ADDR_W(ADDR_W), .BOUNDARY(BOUNDARY)) u_decode (
    .ext_en_i (ext_en_i),
    .addr_i   (req_addr_i),
    .is_ext_o (is_ext)
  );

  assign start = seq_idle && any_req && is_ext;

  xmem_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CYCLES(STROBE_CYCLES)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .start_wr_i    (req_wr_i),
    .start_addr_i  (req_addr_i),
    .start_wdata_i (req_wdata_i),
    .bus_in_i      (ad_i),
    .idle_o        (seq_idle),
    .done_o        (seq_done),
    .rdata_o       (seq_rdata),
    .ale_o         (ale_o),
    .rd_no         (rd_no),
    .wr_no         (wr_no),
    .ad_out_o      (bus_ad),
    .ad_oe_o       (bus_oe),
    .ah_out_o      (bus_ah)
  );

  xmem_pad_mux #(.W(DATA_W)) u_pad_ad (
    .own_i     (ext_en_i),
    .bus_out_i (bus_ad),
    .bus_oe_i  ({DATA_W{bus_oe}}),
    .gp_out_i  (gp_ad_out_i),
    .gp_dir_i  (gp_ad_dir_i),
    .pad_out_o (ad_o),
    .pad_oe_o  (ad_oe_o)
  );

  xmem_pad_mux #(.W(HI_W)) u_pad_ah (
    .own_i     (ext_en_i),
    .bus_out_i (bus_ah),
    .bus_oe_i  ({HI_W{1'b1}}),
    .gp_out_i  (gp_ah_out_i),
    .gp_dir_i  (gp_ah_dir_i),
    .pad_out_o (ah_o),
    .pad_oe_o  (ah_oe_o)
  );

  logic int_hit;
  assign int_hit     = seq_idle && any_req && !is_ext;
  assign int_rd_o    = int_hit && req_rd_i;
  assign int_wr_o    = int_hit && req_wr_i;
  assign req_ready_o = int_hit || seq_done;
  assign req_rdata_o = seq_done ? seq_rdata : int_rdata_i;
endmodule

// File: rtl/xmem_bridge_chk.sv
module xmem_bridge_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ext_en_i,
  input logic              ale_o,
  input logic              rd_no,
  input logic              wr_no,
  input logic [DATA_W-1:0] ad_o,
  input logic [DATA_W-1:0] ad_oe_o,
  input logic              req_ready_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no)); // R8

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (ad_oe_o == '0)); // R8

  AST_ALE_LOW_IN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !ale_o); // R4

  AST_ADDR_HELD_AT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> (ad_oe_o == '1) && (ad_o == $past(ad_o))); // R4

  AST_BUS_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |-> (!ale_o && rd_no && wr_no)); // R3

  AST_READY_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (rd_no && wr_no && !ale_o)); // R7
endmodule

bind xmem_bridge xmem_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ext_en_i    (ext_en_i),
  .ale_o       (ale_o),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .ad_o        (ad_o),
  .ad_oe_o     (ad_oe_o),
  .req_ready_o (req_ready_o)
);

// File: tb/xmem_bridge_bench.sv
`timescale 1ns/1ps
module xmem_bridge_bench;
  localparam int unsigned S     = 2;
  localparam logic [15:0] BOUND = 16'h025F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_en_i = 1'b0;
  logic        req_rd_i = 1'b0, req_wr_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic [7:0]  req_rdata_o;
  logic        req_ready_o, int_rd_o, int_wr_o;
  logic [7:0]  int_rdata_i;
  logic [7:0]  gp_ad_out_i = 8'h3C, gp_ad_dir_i = 8'hF0;
  logic [7:0]  gp_ah_out_i = 8'h81, gp_ah_dir_i = 8'h0F;
  logic [7:0]  ad_o, ad_oe_o, ad_i, ah_o, ah_oe_o;
  logic        ale_o, rd_no, wr_no;

  always #4 clk_i = ~clk_i;

  xmem_bridge #(.BOUNDARY(BOUND), .STROBE_CYCLES(S)) u_xmem_bridge (.*);

  // behavioural external latch + SRAM, and internal RAM
  logic [7:0] sram [int];
  logic [7:0] iram [int];
  logic [7:0] lat_q = '0;
  logic [7:0] sram_rd, iram_rd;

  always @(posedge clk_i) if (ale_o) lat_q <= ad_o;
  always @(posedge clk_i) if (!wr_no) sram[{ah_o, lat_q}] = ad_o;
  always @(posedge clk_i) if (int_wr_o) iram[req_addr_i] = req_wdata_i;
  always @* sram_rd = sram.exists({ah_o, lat_q}) ? sram[{ah_o, lat_q}] : 8'h00;
  always @* iram_rd = iram.exists(req_addr_i) ? iram[req_addr_i] : 8'h00;
  assign ad_i        = !rd_no ? sram_rd : (ad_o & ad_oe_o);
  assign int_rdata_i = iram_rd;

  int checks = 0, errors = 0;
  logic [7:0] exp_q [$];
  logic [7:0] shadow_ext [int];
  logic [7:0] shadow_int [int];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected read data as completions appear
  always @(negedge clk_i) begin
    if (req_rd_i && req_ready_o) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected read", 32'(req_rdata_o), 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(req_rdata_o == e, "R6/R2 read data", 32'(req_rdata_o), 32'(e));
      end
    end
  end

  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] wd, input bit exp_ext);
    int k = 0;
    bit ph_ok = 1, strb_ok = 1, any_strb = 0;
    @(posedge clk_i); #1;
    req_addr_i = a; req_wdata_i = wd; req_wr_i = wr; req_rd_i = !wr;
    if (wr) begin
      if (exp_ext) shadow_ext[a] = wd; else shadow_int[a] = wd;
    end else if (exp_ext) exp_q.push_back(shadow_ext.exists(a) ? shadow_ext[a] : 8'h00);
    else exp_q.push_back(shadow_int.exists(a) ? shadow_int[a] : 8'h00);
    forever begin
      @(negedge clk_i);
      if (!rd_no || !wr_no) any_strb = 1;
      if (req_ready_o) break;
      if (exp_ext) begin
        if (k == 1 && !(ale_o && ad_o == a[7:0] && ad_oe_o == 8'hFF && ah_o == a[15:8])) ph_ok = 0;
        if (k == 2 && !(!ale_o && ad_o == a[7:0] && ad_oe_o == 8'hFF && rd_no && wr_no)) ph_ok = 0;
        if (k >= 3 && k <= 2 + S) begin
          if (ale_o) ph_ok = 0;
          if (wr && !(!wr_no && rd_no && ad_o == wd && ad_oe_o == 8'hFF)) strb_ok = 0;
          if (!wr && !(!rd_no && wr_no && ad_oe_o == 8'h00)) strb_ok = 0;
        end
      end
      k++;
      if (k > 40) break;
    end
    if (exp_ext) begin
      chk(k == 3 + S, "R7 latency", 32'(k), 32'(3 + S));
      chk(ph_ok, "R4 address/latch phases", 32'(ph_ok), 1);
      chk(strb_ok, wr ? "R5 write strobe" : "R6 read strobe", 32'(strb_ok), 1);
    end else begin
      chk(k == 0, "R2 internal one cycle", 32'(k), 0);
      chk(!any_strb && (wr ? int_wr_o : int_rd_o), "R2 internal path", 32'(any_strb), 0);
    end
    @(posedge clk_i); #1;
    req_rd_i = 0; req_wr_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(!ale_o && rd_no && wr_no, "R1 reset idle pins", {29'b0, ale_o, rd_no, wr_no}, 3'b011);
    rst_ni = 1;
    @(posedge clk_i); #1;
    // R3 bus off: GPIO passthrough and internal mapping above boundary
    chk(ad_o == 8'h3C && ad_oe_o == 8'hF0 && ah_o == 8'h81 && ah_oe_o == 8'h0F,
        "R3 pins follow GPIO", {ad_o, ad_oe_o, ah_o, ah_oe_o}, 32'h3CF0810F);
    access(1, 16'h1234, 8'h77, 0);
    access(0, 16'h1234, 8'h00, 0);
    chk(!sram.exists(16'h1234), "R3 no external write when off", 0, 0);
    ext_en_i = 1;
    @(posedge clk_i); #1;
    chk(ad_oe_o == 8'h00 && ah_oe_o == 8'hFF, "R10 idle override", {ad_oe_o, ah_oe_o}, 16'h00FF);
    gp_ad_dir_i = 8'hFF; gp_ah_dir_i = 8'h00; #1;
    chk(ad_oe_o == 8'h00 && ah_oe_o == 8'hFF, "R10 dir ignored", {ad_oe_o, ah_oe_o}, 16'h00FF);
    chk(!ale_o && rd_no && wr_no, "R1 idle with bus on", {29'b0, ale_o, rd_no, wr_no}, 3'b011);
    // R2 internal range with bus on
    access(1, 16'h0100, 8'h5C, 0);
    access(0, 16'h0100, 8'h00, 0);
    // R9 boundary split
    access(1, BOUND, 8'hC3, 0);
    access(1, BOUND + 16'd1, 8'h3D, 1);
    access(0, BOUND, 8'h00, 0);
    access(0, BOUND + 16'd1, 8'h00, 1);
    // R5/R6 external accesses with distinct high/low bytes
    access(1, 16'h1234, 8'h5A, 1);
    access(1, 16'hFF01, 8'hA5, 1);
    chk(sram.exists(16'h1234) && sram[16'h1234] == 8'h5A, "R5 memory content",
        sram.exists(16'h1234) ? 32'(sram[16'h1234]) : 32'hFFFF, 32'h5A);
    access(0, 16'hFF01, 8'h00, 1);
    access(0, 16'h1234, 8'h00, 1);
    access(0, 16'h0260 + 16'd5, 8'h00, 1);
    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0, "R6 all reads completed", 32'(exp_q.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule